// File: doc/BRIEF.md
# Dual-Bank Edge/Level Interrupt Controller

This block collects two groups of interrupt lines, a normal group and a fast group, and turns each group into one request line toward a processor. Every line in every group has three settings of its own: a mask bit, a choice between edge and level sensing, and a choice of which polarity counts as active. External lines are first passed through a two-flop synchroniser. Edge events are held in a per-line latch until software clears them. Level inputs are shown live, corrected for polarity.

Software reaches both groups through one word-addressed register port. Reads are combinational from the current address. Writes take effect on the clock edge that samples the write strobe. Both groups use the same six-register layout: the fast group sits 0x20 above the normal one. Two fixed identification words follow. Ordering the pending lines and producing vectors are left to the consumer of the request lines.

Top module: `irq_dual_bank_ctrl`

## Requirements
- R1: After reset the mask, sense-mode and polarity registers of both groups read zero, every edge latch is empty and both request outputs are low.
- R2: In level mode (mode bit 0, polarity bit 0), source bit i equals input i as it was two clock edges earlier, the delay of the synchroniser.
- R3: A polarity bit of 1 inverts the sensed line. In level mode the source bit is then the complement of the input, and in edge mode a falling edge is the event.
- R4: In edge mode (mode bit 1), a transition toward the active polarity sets the line's latch. The source bit then stays 1 after the input returns to idle.
- R5: Writing the clear register resets the latches whose data bits are 1 and leaves the others alone. An edge detected in the same cycle as the clear keeps its latch set.
- R6: Each status bit is the source bit ANDed with its mask bit, and a request output is high exactly when any status bit of its group is 1.
- R7: Normal group offsets are source 0x00, mask 0x04, clear 0x08, mode 0x0C, polarity 0x10 and status 0x14. The fast group uses the same offsets plus 0x20. Activity in one group never affects the other group's registers or request.
- R8: The mask, mode and polarity registers read back the value last written.
- R9: Writes to the source and status offsets change no register, and the clear offset reads as zero.
- R10: Offset 0x50 returns the revision parameter. Offset 0x54 returns the normal input count in bits 15:8 and the fast input count in bits 7:0, with all other bits zero. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| norm_in | input | NUM_IN | Normal-group interrupt lines, asynchronous |
| fast_in | input | NUM_IN | Fast-group interrupt lines, asynchronous |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address of the register, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| norm_req | output | 1 | Normal-group request |
| fast_req | output | 1 | Fast-group request |

## Verification
The hardest case to reach is an edge being detected in the very cycle in which software clears that line's latch. That cycle comes two edges after the asynchronous input changes, because of the synchroniser and the edge-detect register. The bench drives the input on a falling clock edge and lets exactly one more falling edge pass. It then launches the clear write, so that the write strobe and the freshly detected edge meet at the same rising edge. A follow-up clear with no new edge confirms that the clear itself works.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // register selector inside one group, index equals address bits 4:2
    typedef enum logic [2:0] {
        F_SRC  = 3'd0,
        F_EN   = 3'd1,
        F_CLR  = 3'd2,
        F_MODE = 3'd3,
        F_POL  = 3'd4,
        F_STAT = 3'd5,
        F_NONE = 3'd7
    } irqc_field_e;

    // which region of the map an address falls in
    typedef enum logic [2:0] {
        HIT_NONE,
        HIT_NORM,
        HIT_FAST,
        HIT_REV,
        HIT_CNT
    } irqc_hit_e;

    // per-group write strobes
    typedef struct packed {
        logic en_we;
        logic clr_we;
        logic mode_we;
        logic pol_we;
    } irqc_wr_t;

    localparam int unsigned GRP_SPAN   = 32'h20;
    localparam int unsigned REV_OFFSET = 32'h50;
    localparam int unsigned CNT_OFFSET = 32'h54;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned W      = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stage_q [STAGES];
    logic [W-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign stage_d[s] = din;
            end else begin : g_next
                assign stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/irqc_regdec.sv
module irqc_regdec
    import irqc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output irqc_hit_e         hit,
    output irqc_field_e       field,
    output irqc_wr_t          norm_wr,
    output irqc_wr_t          fast_wr
);

    localparam int unsigned UPPER_W = ADDR_W - 5;

    logic [UPPER_W-1:0] upper;
    logic [2:0]         idx;

    assign upper = bus_addr[ADDR_W-1:5];
    assign idx   = bus_addr[4:2];

    always_comb begin
        hit   = HIT_NONE;
        field = F_NONE;
        if (bus_addr[1:0] == 2'b00) begin
            if (upper == UPPER_W'(0) || upper == UPPER_W'(1)) begin
                if (idx <= 3'd5) begin
                    hit   = (upper == UPPER_W'(0)) ? HIT_NORM : HIT_FAST;
                    field = irqc_field_e'(idx);
                end
            end else if (bus_addr == ADDR_W'(REV_OFFSET)) begin
                hit = HIT_REV;
            end else if (bus_addr == ADDR_W'(CNT_OFFSET)) begin
                hit = HIT_CNT;
            end
        end
    end

    function automatic irqc_wr_t strobes(input logic sel, input irqc_field_e f);
        irqc_wr_t s;
        s.en_we   = sel && (f == F_EN);
        s.clr_we  = sel && (f == F_CLR);
        s.mode_we = sel && (f == F_MODE);
        s.pol_we  = sel && (f == F_POL);
        return s;
    endfunction

    assign norm_wr = strobes(bus_wr && (hit == HIT_NORM), field);
    assign fast_wr = strobes(bus_wr && (hit == HIT_FAST), field);

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_sync,
    input  irqc_wr_t     wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] en,
    output logic [N-1:0] mode,
    output logic [N-1:0] pol,
    output logic [N-1:0] lat,
    output logic [N-1:0] src,
    output logic [N-1:0] stat,
    output logic         req
);

    typedef struct packed {
        logic [N-1:0] en;
        logic [N-1:0] mode;
        logic [N-1:0] pol;
        logic [N-1:0] prev;
        logic [N-1:0] lat;
    } bank_st_t;

    bank_st_t st_d, st_q;

    logic [N-1:0] lvl_now, lvl_prev, edge_hit, clr_mask;

    always_comb begin
        // polarity-corrected view; prev uses current polarity so a
        // polarity change alone never looks like an edge
        lvl_now  = line_sync ^ st_q.pol;
        lvl_prev = st_q.prev ^ st_q.pol;
        edge_hit = lvl_now & ~lvl_prev;
        clr_mask = wr.clr_we ? wdata : '0;

        st_d      = st_q;
        st_d.prev = line_sync;
        if (wr.en_we)   st_d.en   = wdata;
        if (wr.mode_we) st_d.mode = wdata;
        if (wr.pol_we)  st_d.pol  = wdata;
        // new edge has priority over a clear in the same cycle
        st_d.lat = st_q.mode & (edge_hit | (st_q.lat & ~clr_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign mode = st_q.mode;
    assign pol  = st_q.pol;
    assign lat  = st_q.lat;
    assign src  = (st_q.mode & st_q.lat) | (~st_q.mode & lvl_now);
    assign stat = src & st_q.en;
    assign req  = |stat;

endmodule

// File: rtl/irq_dual_bank_ctrl.sv
module irq_dual_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN      = 32,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [31:0] REV_ID      = 32'h0001_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] norm_in,
    input  logic [NUM_IN-1:0] fast_in,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              norm_req,
    output logic              fast_req
);

    localparam logic [7:0]  CNT_BYTE = 8'(NUM_IN);
    localparam logic [31:0] CNT_WORD = {16'h0000, CNT_BYTE, CNT_BYTE};

    irqc_hit_e   hit;
    irqc_field_e field;
    irqc_wr_t    n_wr, f_wr;

    logic [NUM_IN-1:0] n_sync, f_sync;
    logic [NUM_IN-1:0] n_en, n_mode, n_pol, n_lat, n_src, n_stat;
    logic [NUM_IN-1:0] f_en, f_mode, f_pol, f_lat, f_src, f_stat;

    irqc_regdec #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .hit     (hit),
        .field   (field),
        .norm_wr (n_wr),
        .fast_wr (f_wr)
    );

    irqc_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_nsync (
        .clk(clk), .rst_n(rst_n), .din(norm_in), .dout(n_sync)
    );

    irqc_sync #(.W(NUM_IN), .STAGES(SYNC_STAGES)) u_fsync (
        .clk(clk), .rst_n(rst_n), .din(fast_in), .dout(f_sync)
    );

    irqc_bank #(.N(NUM_IN)) u_nbank (
        .clk(clk), .rst_n(rst_n), .line_sync(n_sync), .wr(n_wr),
        .wdata(bus_wdata[NUM_IN-1:0]),
        .en(n_en), .mode(n_mode), .pol(n_pol), .lat(n_lat),
        .src(n_src), .stat(n_stat), .req(norm_req)
    );

    irqc_bank #(.N(NUM_IN)) u_fbank (
        .clk(clk), .rst_n(rst_n), .line_sync(f_sync), .wr(f_wr),
        .wdata(bus_wdata[NUM_IN-1:0]),
        .en(f_en), .mode(f_mode), .pol(f_pol), .lat(f_lat),
        .src(f_src), .stat(f_stat), .req(fast_req)
    );

    function automatic logic [31:0] widen(input logic [NUM_IN-1:0] v);
        logic [31:0] w;
        w = '0;
        w[NUM_IN-1:0] = v;
        return w;
    endfunction

    function automatic logic [31:0] pick(
        input irqc_field_e f,
        input logic [NUM_IN-1:0] s, e, m, p, st
    );
        case (f)
            F_SRC:   return widen(s);
            F_EN:    return widen(e);
            F_MODE:  return widen(m);
            F_POL:   return widen(p);
            F_STAT:  return widen(st);
            default: return 32'h0;
        endcase
    endfunction

    always_comb begin
        case (hit)
            HIT_NORM: bus_rdata = pick(field, n_src, n_en, n_mode, n_pol, n_stat);
            HIT_FAST: bus_rdata = pick(field, f_src, f_en, f_mode, f_pol, f_stat);
            HIT_REV:  bus_rdata = REV_ID;
            HIT_CNT:  bus_rdata = CNT_WORD;
            default:  bus_rdata = 32'h0;
        endcase
    end

endmodule

// File: rtl/irqc_chk.sv
module irqc_chk #(
    parameter int unsigned N      = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clr_stb,
    input logic [N-1:0]      n_en,
    input logic [N-1:0]      n_mode,
    input logic [N-1:0]      n_lat,
    input logic [N-1:0]      f_en,
    input logic              norm_req,
    input logic              fast_req
);

    // R1: state is idle in the first cycle out of reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $rose(rst_n) |-> (n_en == '0 && f_en == '0 && n_lat == '0 && !norm_req && !fast_req));

    // R6: a fully masked normal group raises no request
    a_r6_masked_norm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (n_en == '0) |-> !norm_req);

    // R7: the fast group behaves the same on its own mask
    a_r7_masked_fast_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (f_en == '0) |-> !fast_req);

    // R4: a latched edge-mode line stays latched while no clear is written
    a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> ((n_lat & $past(n_lat & n_mode)) == $past(n_lat & n_mode)));

    // R9: writes to the source or status offset leave the mask untouched
    a_r9_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_addr == ADDR_W'(8'h00) || bus_addr == ADDR_W'(8'h14))) |=> $stable(n_en));

endmodule

bind irq_dual_bank_ctrl irqc_chk #(.N(NUM_IN), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .clr_stb (n_wr.clr_we),
    .n_en    (n_en),
    .n_mode  (n_mode),
    .n_lat   (n_lat),
    .f_en    (f_en),
    .norm_req(norm_req),
    .fast_req(fast_req)
);

// File: tb/sim_irq_dual_bank_ctrl.sv
`timescale 1ns/1ps
module sim_irq_dual_bank_ctrl;

    localparam int unsigned NI = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] norm_in = '0;
    logic [NI-1:0] fast_in = '0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          norm_req, fast_req;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    irq_dual_bank_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .norm_in(norm_in), .fast_in(fast_in),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .norm_req(norm_req), .fast_req(fast_req)
    );

    typedef struct packed {
        logic [31:0] en;
        logic [31:0] mode;
        logic [31:0] pol;
        logic [31:0] pre;
        logic [31:0] pin;
        logic [31:0] src;
    } vec_t;

    // normal group: config, input before, input after, expected source
    localparam vec_t VEC [6] = '{
        '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000, 32'h0, 32'h0000_00A5, 32'h0000_00A5}, // R2
        '{32'h00F0_00FF, 32'h0000_0000, 32'hFFFF_0000, 32'h0, 32'h0001_0000, 32'hFFFE_0000}, // R3
        '{32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000, 32'h0, 32'h0000_000F, 32'h0000_000F}, // R4
        '{32'h0000_0080, 32'h0000_00F0, 32'h0000_00F0, 32'hF0, 32'h0000_0030, 32'h0000_00C0}, // R3 falling
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000, 32'h1, 32'h0000_0001, 32'h0000_0000}, // R4 no edge
        '{32'h0000_0000, 32'h0000_FF00, 32'h0000_0000, 32'h0, 32'h0000_0F0F, 32'h0000_0F0F}  // R6 masked
    };

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] rd;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h04, rd); check("R1 mask", rd, 32'h0);
        bus_read(8'h0C, rd); check("R1 mode", rd, 32'h0);
        bus_read(8'h30, rd); check("R1 fast pol", rd, 32'h0);
        bus_read(8'h14, rd); check("R1 status", rd, 32'h0);
        check("R1 reqs", {30'h0, norm_req, fast_req}, 32'h0);

        // table walk over the normal group
        for (int i = 0; i < 6; i++) begin
            bus_write(8'h04, VEC[i].en);
            bus_write(8'h0C, VEC[i].mode);
            bus_write(8'h10, VEC[i].pol);
            norm_in = VEC[i].pre;
            settle();
            bus_write(8'h08, 32'hFFFF_FFFF);
            norm_in = VEC[i].pin;
            settle();
            bus_read(8'h00, rd); check($sformatf("R2/R3/R4 src vec%0d", i), rd, VEC[i].src);
            bus_read(8'h14, rd); check($sformatf("R6 status vec%0d", i), rd, VEC[i].src & VEC[i].en);
            check($sformatf("R6 req vec%0d", i), {31'h0, norm_req}, {31'h0, |(VEC[i].src & VEC[i].en)});
        end

        // R8 read back and R7 fast offsets
        bus_write(8'h04, 32'h1234_5678);
        bus_read(8'h04, rd); check("R8 mask readback", rd, 32'h1234_5678);
        bus_write(8'h2C, 32'hA5A5_0F0F);
        bus_read(8'h2C, rd); check("R7 fast mode readback", rd, 32'hA5A5_0F0F);
        bus_read(8'h0C, rd); check("R7 normal mode untouched", rd, 32'h0000_FF00);

        // R4 latch holds after input returns idle; R5 partial clear
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h0C, 32'h0000_0003);
        bus_write(8'h10, 32'h0);
        norm_in = '0;
        settle();
        bus_write(8'h08, 32'hFFFF_FFFF);
        norm_in = 32'h3;
        settle();
        norm_in = 32'h0;
        settle();
        bus_read(8'h00, rd); check("R4 latch holds", rd, 32'h3);
        bus_write(8'h08, 32'h1);
        bus_read(8'h00, rd); check("R5 partial clear", rd, 32'h2);
        bus_write(8'h08, 32'h2);
        bus_read(8'h00, rd); check("R5 full clear", rd, 32'h0);
        check("R6 req drops", {31'h0, norm_req}, 32'h0);

        // R5 edge in the same cycle as a clear wins
        @(negedge clk);
        norm_in = 32'h1;
        @(negedge clk);
        bus_write(8'h08, 32'h1);
        bus_read(8'h00, rd); check("R5 edge beats clear", rd, 32'h1);
        bus_write(8'h08, 32'h1);
        bus_read(8'h00, rd); check("R5 clear afterwards", rd, 32'h0);
        norm_in = '0;
        settle();

        // R9 read-only offsets ignore writes; clear reads zero
        bus_write(8'h00, 32'hDEAD_BEEF);
        bus_write(8'h14, 32'hDEAD_BEEF);
        bus_read(8'h04, rd); check("R9 mask untouched", rd, 32'hFFFF_FFFF);
        bus_read(8'h0C, rd); check("R9 mode untouched", rd, 32'h3);
        bus_read(8'h00, rd); check("R9 source untouched", rd, 32'h0);
        bus_read(8'h08, rd); check("R9 clear reads zero", rd, 32'h0);

        // R10 identification and unmapped
        bus_read(8'h50, rd); check("R10 revision", rd, 32'h0001_0003);
        bus_read(8'h54, rd); check("R10 counts", rd, 32'h0000_2020);
        bus_read(8'h40, rd); check("R10 unmapped", rd, 32'h0);
        bus_read(8'h18, rd); check("R10 gap", rd, 32'h0);

        // R7 fast group independent of normal
        bus_write(8'h04, 32'h0);
        bus_write(8'h24, 32'h0000_0100);
        bus_write(8'h2C, 32'h0);
        fast_in = 32'h0000_0100;
        settle();
        bus_read(8'h34, rd); check("R7 fast status", rd, 32'h0000_0100);
        check("R7 fast req", {30'h0, norm_req, fast_req}, 32'h1);
        bus_read(8'h14, rd); check("R7 normal status clear", rd, 32'h0);

        finish_run();
    end

endmodule